// File: doc/BRIEF.md
# ATA Channel Device Probe and Identify Engine

This block walks one parallel ATA channel after power-up and works out what is attached to it. A `start` pulse makes it visit the master position and then the slave position. For each position it selects the drive, waits a programmable settle time, and reads the status byte. If the status byte is not conclusive, it also reads the two cylinder registers to look for the packet-device signature. For each hard disk found it disables interrupts, issues IDENTIFY and polls for completion within a fixed number of polls. It then streams the 256-word parameter block from the data port and picks out the geometry, the LBA capability and the total sector count.

The register bus is a simple single-cycle port. In any cycle the engine raises at most one strobe, `bus_rd` or `bus_wr`. Read data on `bus_rdata` (8-bit registers) or `bus_data` (the 16-bit data port at offset 0) is sampled in the same cycle as the strobe. `bus_ctl` steers an access to the device control register instead of the task-file offset on `bus_addr`. Results are held per position (index 0 = master, 1 = slave) until the next `start`, and a one-cycle `done` marks them valid.

The state machine uses these states:
- IDLE waits for `start`. Taking `start` clears all results.
- SEL writes the drive/head register and leads to SETTLE.
- SETTLE waits out the settle count and leads to STAT.
- STAT reads status. From there the engine goes to NEXT when the status rules out a disk or a device, to CTL for a disk, or to CYL_LO when the status is inconclusive.
- CYL_LO and CYL_HI read the signature bytes, then lead to NEXT.
- CTL writes the control byte and CMD issues IDENTIFY.
- POLL re-reads status. It goes to XFER on success or to NEXT on error.
- XFER performs the 256 data reads and leads to STORE, which latches the extracted fields.
- NEXT moves from the master to SEL for the slave, or from the slave to DONE.
- DONE pulses `done` and returns to IDLE.

Top module: `ata_probe_engine`

## Requirements
- R1: Each probe selects the master first by writing 0xA0 to offset 6, then the slave by writing 0xB0 (bit 4 = slave) to offset 6, with `bus_ctl` low; `bus_rd` and `bus_wr` are never high together.
- R2: The first status read (offset 7) after a select write occurs no sooner than `settle_cycles`+1 clock cycles after that write.
- R3: Type code per position (0 = empty, 1 = hard disk, 2 = packet device): status bit 7 set gives 0; otherwise status bit 6 or bit 4 set gives 1; otherwise offset 4 reading 0x14 and offset 5 reading 0xEB gives 2, anything else gives 0.
- R4: Only for a hard disk, the engine writes 0x0A to the device control register (`bus_ctl` high), then command 0xEC to offset 7.
- R5: After IDENTIFY the engine re-reads status while bit 7 is set, at most MAX_POLLS reads. If bit 3 is clear in the last status read, the error flag is set, no data word is read, and geometry, LBA flag and capacity stay 0.
- R6: On success exactly 256 reads of offset 0 follow; cylinders come from word 1, heads from word 3 and sectors per track from word 6.
- R7: The LBA flag is 1 only if bit 9 of word 49, a nonzero word 80, bit 0 of word 53 and bit 0 of the 32-bit value {word 61, word 60} are all set.
- R8: For the geometry 16383 cylinders / 16 heads / 63 sectors, capacity is {word 61, word 60} when LBA is set. If LBA is not set, capacity is 0 and the error flag is set. For any other geometry, capacity is the low 32 bits of cylinders × heads × sectors.
- R9: `done` is high for exactly one cycle after both positions are finished. `start` clears every result, so a position that is not a disk, or that failed in R5, reports all fields 0 apart from its type and error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a probe of both positions (taken in IDLE) |
| settle_cycles | input | SETTLE_W | Extra wait after a select write |
| bus_addr | output | 3 | Task-file register offset |
| bus_ctl | output | 1 | Access targets the device control register |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | 8-bit register read data, same cycle as `bus_rd` |
| bus_data | input | 16 | Data-port read data, same cycle as `bus_rd` at offset 0 |
| done | output | 1 | One-cycle pulse, results valid |
| dev_type | output | 2×2 | Type code per position |
| dev_cyl | output | 2×16 | Cylinders per position |
| dev_heads | output | 2×16 | Heads per position |
| dev_sects | output | 2×16 | Sectors per track per position |
| dev_lba | output | 2 | LBA capable per position |
| dev_capacity | output | 2×32 | Total sectors per position |
| dev_err | output | 2 | Identify or capacity error per position |

## Verification
The scoreboard runs several channel setups. They cover a status byte with BSY set alongside ready bits, a DSC-only disk, a half-matching signature, a big-geometry disk both with and without LBA, an LBA set where only one of the four conditions fails, a disk that never raises DRQ, and a disk that stays busy past the poll limit. Each setup catches a specific fault. Classification in the wrong priority order turns an empty slot into a disk. A wrong byte lane on word 49 flips the LBA flag. A missing poll bound hangs the engine or gives the wrong read count. An unguarded transfer reads data after a DRQ failure. Results not cleared on `start` leak geometry from the previous probe. Settle gaps are measured on the bus with the settle count set to 0 and to several nonzero values.

// File: rtl/ata_probe_pkg.sv
package ata_probe_pkg;
    localparam int WORD_W      = 16;
    localparam int CAP_W       = 32;
    localparam int BLOCK_WORDS = 256;
    localparam int IDX_W       = $clog2(BLOCK_WORDS);
    localparam int NPOS        = 2;

    typedef enum logic [1:0] {
        KIND_EMPTY  = 2'd0,
        KIND_DISK   = 2'd1,
        KIND_PACKET = 2'd2
    } dev_kind_t;

    localparam logic [2:0] OFS_DATA   = 3'd0;
    localparam logic [2:0] OFS_SIG_LO = 3'd4;
    localparam logic [2:0] OFS_SIG_HI = 3'd5;
    localparam logic [2:0] OFS_SELECT = 3'd6;
    localparam logic [2:0] OFS_STATUS = 3'd7;

    localparam logic [7:0] SEL_BASE    = 8'hA0;
    localparam logic [7:0] CTL_QUIET   = 8'h0A;
    localparam logic [7:0] CMD_IDENT   = 8'hEC;
    localparam logic [7:0] SIG_LO_VAL  = 8'h14;
    localparam logic [7:0] SIG_HI_VAL  = 8'hEB;

    localparam int ST_BUSY  = 7;
    localparam int ST_READY = 6;
    localparam int ST_SEEK  = 4;
    localparam int ST_DREQ  = 3;
endpackage

// File: rtl/ata_step_counter.sv
module ata_step_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         at_limit
);
    assign at_limit = (count == limit);

    always_ff @(posedge clk) begin
        if (!rst_n)               count <= '0;
        else if (clr)             count <= '0;
        else if (en && !at_limit) count <= count + 1'b1;
    end
endmodule

// File: rtl/ata_ident_capture.sv
module ata_ident_capture
    import ata_probe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              word_valid,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] cyl,
    output logic [WORD_W-1:0] heads,
    output logic [WORD_W-1:0] sects,
    output logic              lba_ok,
    output logic [CAP_W-1:0]  capacity,
    output logic              cap_err
);
    logic              cap_bit, valid_bit, ver_nz;
    logic [WORD_W-1:0] lba_lo, lba_hi;
    logic [47:0]       chs_prod;
    logic              chs_big;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cyl <= '0; heads <= '0; sects <= '0;
            cap_bit <= 1'b0; valid_bit <= 1'b0; ver_nz <= 1'b0;
            lba_lo <= '0; lba_hi <= '0;
        end else if (word_valid) begin
            unique case (word_idx)
                8'd1:    cyl       <= word;
                8'd3:    heads     <= word;
                8'd6:    sects     <= word;
                8'd49:   cap_bit   <= word[9];
                8'd53:   valid_bit <= word[0];
                8'd60:   lba_lo    <= word;
                8'd61:   lba_hi    <= word;
                8'd80:   ver_nz    <= (word != '0);
                default: ;
            endcase
        end
    end

    assign lba_ok   = cap_bit && ver_nz && valid_bit && lba_lo[0];
    assign chs_prod = {32'd0, cyl} * {32'd0, heads} * {32'd0, sects};
    assign chs_big  = (cyl == 16'd16383) && (heads == 16'd16) && (sects == 16'd63);

    always_comb begin
        if (chs_big) capacity = lba_ok ? {lba_hi, lba_lo} : '0;
        else         capacity = chs_prod[CAP_W-1:0];
    end
    assign cap_err = chs_big && !lba_ok;

    p_cap_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_err |-> (capacity == '0));
endmodule

// File: rtl/ata_probe_engine.sv
module ata_probe_engine
    import ata_probe_pkg::*;
#(
    parameter int MAX_POLLS = 30000,
    parameter int SETTLE_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [SETTLE_W-1:0]            settle_cycles,
    output logic [2:0]                     bus_addr,
    output logic                           bus_ctl,
    output logic                           bus_rd,
    output logic                           bus_wr,
    output logic [7:0]                     bus_wdata,
    input  logic [7:0]                     bus_rdata,
    input  logic [WORD_W-1:0]              bus_data,
    output logic                           done,
    output logic [NPOS-1:0][1:0]           dev_type,
    output logic [NPOS-1:0][WORD_W-1:0]    dev_cyl,
    output logic [NPOS-1:0][WORD_W-1:0]    dev_heads,
    output logic [NPOS-1:0][WORD_W-1:0]    dev_sects,
    output logic [NPOS-1:0]                dev_lba,
    output logic [NPOS-1:0][CAP_W-1:0]     dev_capacity,
    output logic [NPOS-1:0]                dev_err
);
    localparam int                POLL_W     = $clog2(MAX_POLLS + 1);
    localparam logic [POLL_W-1:0] POLL_LIMIT = POLL_W'(MAX_POLLS - 1);

    typedef enum logic [3:0] {
        S_IDLE, S_SEL, S_SETTLE, S_STAT, S_CYL_LO, S_CYL_HI, S_CTL,
        S_CMD, S_POLL, S_XFER, S_STORE, S_NEXT, S_DONE
    } state_t;

    state_t            state, state_nx;
    logic              pos;
    logic              sig_lo_hit;
    logic [IDX_W-1:0]  word_cnt;
    logic [SETTLE_W-1:0] settle_cnt;
    logic              settle_hit;
    logic [POLL_W-1:0] poll_cnt;
    logic              poll_hit;
    logic              st_busy, st_dreq, st_disk, poll_end;
    logic [WORD_W-1:0] c_cyl, c_heads, c_sects;
    logic              c_lba, c_err;
    logic [CAP_W-1:0]  c_cap;

    ata_step_counter #(.W(SETTLE_W)) u_settle (
        .clk(clk), .rst_n(rst_n), .clr(state != S_SETTLE), .en(state == S_SETTLE),
        .limit(settle_cycles), .count(settle_cnt), .at_limit(settle_hit));

    ata_step_counter #(.W(POLL_W)) u_poll (
        .clk(clk), .rst_n(rst_n), .clr(state != S_POLL), .en(state == S_POLL),
        .limit(POLL_LIMIT), .count(poll_cnt), .at_limit(poll_hit));

    ata_ident_capture u_cap (
        .clk(clk), .rst_n(rst_n), .clr(state == S_CMD),
        .word_valid(state == S_XFER), .word_idx(word_cnt), .word(bus_data),
        .cyl(c_cyl), .heads(c_heads), .sects(c_sects),
        .lba_ok(c_lba), .capacity(c_cap), .cap_err(c_err));

    assign st_busy  = bus_rdata[ST_BUSY];
    assign st_dreq  = bus_rdata[ST_DREQ];
    assign st_disk  = bus_rdata[ST_READY] || bus_rdata[ST_SEEK];
    assign poll_end = !st_busy || poll_hit;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (start) state_nx = S_SEL;
            S_SEL:    state_nx = S_SETTLE;
            S_SETTLE: if (settle_hit) state_nx = S_STAT;
            S_STAT:   state_nx = st_busy ? S_NEXT : (st_disk ? S_CTL : S_CYL_LO);
            S_CYL_LO: state_nx = S_CYL_HI;
            S_CYL_HI: state_nx = S_NEXT;
            S_CTL:    state_nx = S_CMD;
            S_CMD:    state_nx = S_POLL;
            S_POLL:   if (poll_end) state_nx = st_dreq ? S_XFER : S_NEXT;
            S_XFER:   if (word_cnt == IDX_W'(BLOCK_WORDS - 1)) state_nx = S_STORE;
            S_STORE:  state_nx = S_NEXT;
            S_NEXT:   state_nx = pos ? S_DONE : S_SEL;
            S_DONE:   state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // bus outputs
    always_comb begin
        bus_addr = OFS_DATA; bus_ctl = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
        bus_wdata = 8'h00;   done = 1'b0;
        unique case (state)
            S_SEL:    begin bus_wr = 1'b1; bus_addr = OFS_SELECT;
                            bus_wdata = SEL_BASE | {3'b000, pos, 4'b0000}; end
            S_STAT,
            S_POLL:   begin bus_rd = 1'b1; bus_addr = OFS_STATUS; end
            S_CYL_LO: begin bus_rd = 1'b1; bus_addr = OFS_SIG_LO; end
            S_CYL_HI: begin bus_rd = 1'b1; bus_addr = OFS_SIG_HI; end
            S_CTL:    begin bus_wr = 1'b1; bus_ctl = 1'b1; bus_wdata = CTL_QUIET; end
            S_CMD:    begin bus_wr = 1'b1; bus_addr = OFS_STATUS; bus_wdata = CMD_IDENT; end
            S_XFER:   begin bus_rd = 1'b1; bus_addr = OFS_DATA; end
            S_DONE:   done = 1'b1;
            default:  ;
        endcase
    end

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= 1'b0; sig_lo_hit <= 1'b0; word_cnt <= '0;
            dev_type <= '0; dev_cyl <= '0; dev_heads <= '0; dev_sects <= '0;
            dev_lba <= '0; dev_capacity <= '0; dev_err <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    pos <= 1'b0;
                    dev_type <= '0; dev_cyl <= '0; dev_heads <= '0; dev_sects <= '0;
                    dev_lba <= '0; dev_capacity <= '0; dev_err <= '0;
                end
                S_STAT:   if (!st_busy && st_disk) dev_type[pos] <= KIND_DISK;
                S_CYL_LO: sig_lo_hit <= (bus_rdata == SIG_LO_VAL);
                S_CYL_HI: if (sig_lo_hit && bus_rdata == SIG_HI_VAL) dev_type[pos] <= KIND_PACKET;
                S_CMD:    word_cnt <= '0;
                S_POLL:   if (poll_end && !st_dreq) dev_err[pos] <= 1'b1;
                S_XFER:   word_cnt <= word_cnt + 1'b1;
                S_STORE: begin
                    dev_cyl[pos] <= c_cyl;     dev_heads[pos] <= c_heads;
                    dev_sects[pos] <= c_sects; dev_lba[pos] <= c_lba;
                    dev_capacity[pos] <= c_cap; dev_err[pos] <= c_err;
                end
                S_NEXT:   pos <= 1'b1;
                default:  ;
            endcase
        end
    end

    p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    p_sel_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_ctl && bus_addr == OFS_SELECT) |-> (bus_wdata inside {8'hA0, 8'hB0}));
    p_settle_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STAT) |-> ($past(state) == S_SETTLE));
    p_type_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_type[0] != 2'd3) && (dev_type[1] != 2'd3));
    p_poll_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_POLL) |-> (poll_cnt <= POLL_LIMIT));
    p_full_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STORE) |-> ($past(word_cnt) == IDX_W'(BLOCK_WORDS - 1)));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/ata_probe_engine_tb.sv
`timescale 1ns/1ps
module ata_probe_engine_tb;
    localparam int MAXP = 30000;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [7:0] settle_cycles = 8'd0;
    logic [2:0] bus_addr; logic bus_ctl, bus_rd, bus_wr, done;
    logic [7:0] bus_wdata, bus_rdata; logic [15:0] bus_data;
    logic [1:0][1:0] dev_type; logic [1:0][15:0] dev_cyl, dev_heads, dev_sects;
    logic [1:0] dev_lba, dev_err; logic [1:0][31:0] dev_capacity;

    always #2 clk = ~clk;

    ata_probe_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
        .bus_addr(bus_addr), .bus_ctl(bus_ctl), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_data(bus_data),
        .done(done), .dev_type(dev_type), .dev_cyl(dev_cyl), .dev_heads(dev_heads),
        .dev_sects(dev_sects), .dev_lba(dev_lba), .dev_capacity(dev_capacity),
        .dev_err(dev_err));

    // channel model configuration
    logic [7:0]  cfg_stat[2], cfg_cl[2], cfg_ch[2], cfg_capb[2];
    logic [15:0] cfg_cyl[2], cfg_hd[2], cfg_sc[2], cfg_w53[2], cfg_w80[2];
    logic [31:0] cfg_lba[2];
    int          cfg_busy[2];
    logic        cfg_drq[2];

    logic m_sel, m_cmd; int m_busy, m_widx;

    function automatic logic [15:0] id_word(input logic d, input int i);
        case (i)
            1:  return cfg_cyl[d];
            3:  return cfg_hd[d];
            6:  return cfg_sc[d];
            49: return {cfg_capb[d], 8'h3C};
            53: return cfg_w53[d];
            60: return cfg_lba[d][15:0];
            61: return cfg_lba[d][31:16];
            80: return cfg_w80[d];
            default: return 16'(i * 7) ^ 16'h1234;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin m_sel <= 0; m_cmd <= 0; m_busy <= 0; m_widx <= 0; end
        else begin
            if (bus_wr && !bus_ctl && bus_addr == 3'd6) begin m_sel <= bus_wdata[4]; m_cmd <= 0; end
            if (bus_wr && !bus_ctl && bus_addr == 3'd7) begin m_cmd <= 1; m_busy <= cfg_busy[m_sel]; m_widx <= 0; end
            if (bus_rd && !bus_ctl && bus_addr == 3'd7 && m_cmd && m_busy > 0) m_busy <= m_busy - 1;
            if (bus_rd && !bus_ctl && bus_addr == 3'd0) m_widx <= m_widx + 1;
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (!bus_ctl) case (bus_addr)
            3'd7: bus_rdata = m_cmd ? ((m_busy > 0) ? 8'h80 : (cfg_drq[m_sel] ? 8'h58 : 8'h50))
                                    : cfg_stat[m_sel];
            3'd4: bus_rdata = cfg_cl[m_sel];
            3'd5: bus_rdata = cfg_ch[m_sel];
            default: bus_rdata = 8'h00;
        endcase
        bus_data = id_word(m_sel, m_widx);
    end

    // scoreboard
    typedef struct {
        logic [1:0] typ; logic [15:0] cyl, hd, sc; logic lba; logic [31:0] cap;
        logic err; int polls, words, ident;
    } exp_t;
    exp_t sb_q[$];
    int n_chk = 0, n_bad = 0, cyc = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin n_bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
    endtask

    function automatic exp_t predict(input logic d);
        exp_t e; logic big;
        e = '{typ:0, cyl:0, hd:0, sc:0, lba:0, cap:0, err:0, polls:0, words:0, ident:0};
        if (cfg_stat[d][7]) e.typ = 0;
        else if (cfg_stat[d][6] || cfg_stat[d][4]) e.typ = 1;
        else if (cfg_cl[d] == 8'h14 && cfg_ch[d] == 8'hEB) e.typ = 2;
        if (e.typ == 1) begin
            e.ident = 1;
            e.polls = (cfg_busy[d] + 1 > MAXP) ? MAXP : cfg_busy[d] + 1;
            if (cfg_busy[d] >= MAXP || !cfg_drq[d]) e.err = 1;
            else begin
                e.words = 256; e.cyl = cfg_cyl[d]; e.hd = cfg_hd[d]; e.sc = cfg_sc[d];
                e.lba = cfg_capb[d][1] && cfg_w80[d] != 0 && cfg_w53[d][0] && cfg_lba[d][0];
                big = cfg_cyl[d] == 16383 && cfg_hd[d] == 16 && cfg_sc[d] == 63;
                if (big) begin e.cap = e.lba ? cfg_lba[d] : 0; e.err = !e.lba; end
                else e.cap = 32'(48'(cfg_cyl[d]) * 48'(cfg_hd[d]) * 48'(cfg_sc[d]));
            end
        end
        return e;
    endfunction

    // bus and result monitor
    int sel_seen = 0, sel_cyc = 0, cur = 0, cur_settle = 0;
    bit pend = 0, in_poll = 0, ctl_last = 0;
    int polls_c[2], words_c[2], ident_c[2];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) if (rst_n) begin
        if (bus_wr && !bus_ctl && bus_addr == 3'd6) begin
            check(bus_wdata == ((sel_seen == 0) ? 8'hA0 : 8'hB0), "R1 select code",
                  bus_wdata, (sel_seen == 0) ? 8'hA0 : 8'hB0);
            sel_seen++; sel_cyc = cyc; pend = 1; in_poll = 0; cur = bus_wdata[4];
        end
        if (bus_rd && bus_wr) check(0, "R1 strobe overlap", 1, 0);
        if (bus_rd && !bus_ctl && bus_addr == 3'd7 && pend) begin
            check(cyc - sel_cyc >= cur_settle + 1, "R2 settle gap", cyc - sel_cyc, cur_settle + 1);
            pend = 0;
        end else if (bus_rd && !bus_ctl && bus_addr == 3'd7 && in_poll) polls_c[cur]++;
        if (bus_wr && bus_ctl) begin
            check(bus_wdata == 8'h0A, "R4 control byte", bus_wdata, 8'h0A); ctl_last = 1;
        end else if (bus_wr && bus_addr == 3'd7) begin
            check(bus_wdata == 8'hEC && ctl_last, "R4 identify command", bus_wdata, 8'hEC);
            ident_c[cur]++; in_poll = 1; ctl_last = 0;
        end
        if (bus_rd && !bus_ctl && bus_addr == 3'd0) words_c[cur]++;
        if (done) begin
            for (int d = 0; d < 2; d++) begin
                exp_t e;
                if (sb_q.size() == 0) begin check(0, "R9 unexpected done", 1, 0); break; end
                e = sb_q.pop_front();
                check(dev_type[d] == e.typ, $sformatf("R3 type pos%0d", d), dev_type[d], e.typ);
                check(ident_c[d] == e.ident, $sformatf("R4 identify count pos%0d", d), ident_c[d], e.ident);
                check(polls_c[d] == e.polls, $sformatf("R5 poll count pos%0d", d), polls_c[d], e.polls);
                check(words_c[d] == e.words, $sformatf("R6 word reads pos%0d", d), words_c[d], e.words);
                check(dev_cyl[d] == e.cyl && dev_heads[d] == e.hd && dev_sects[d] == e.sc,
                      $sformatf("R6 geometry pos%0d", d),
                      {dev_cyl[d], dev_heads[d], dev_sects[d]}, {e.cyl, e.hd, e.sc});
                check(dev_lba[d] == e.lba, $sformatf("R7 lba pos%0d", d), dev_lba[d], e.lba);
                check(dev_capacity[d] == e.cap, $sformatf("R8 capacity pos%0d", d), dev_capacity[d], e.cap);
                check(dev_err[d] == e.err, $sformatf("R5/R8 error pos%0d", d), dev_err[d], e.err);
            end
            sel_seen = 0;
            for (int d = 0; d < 2; d++) begin polls_c[d] = 0; words_c[d] = 0; ident_c[d] = 0; end
        end
    end

    task automatic cfg(input int d, input logic [7:0] st, cl, ch, input logic [15:0] cy, hd, sc,
                       input logic [7:0] capb, input logic [15:0] w53, w80, input logic [31:0] lba,
                       input int busy, input logic drq);
        cfg_stat[d] = st; cfg_cl[d] = cl; cfg_ch[d] = ch; cfg_cyl[d] = cy; cfg_hd[d] = hd;
        cfg_sc[d] = sc; cfg_capb[d] = capb; cfg_w53[d] = w53; cfg_w80[d] = w80;
        cfg_lba[d] = lba; cfg_busy[d] = busy; cfg_drq[d] = drq;
    endtask

    task automatic run_probe(input int settle);
        int dn;
        settle_cycles = 8'(settle); cur_settle = settle;
        sb_q.push_back(predict(0)); sb_q.push_back(predict(1));
        @(negedge clk); start = 1; @(negedge clk); start = 0;
        while (!done) @(negedge clk);
        @(negedge clk);
        check(!done, "R9 done single cycle", done, 0);
        dn = 0;
        for (int k = 0; k < 20; k++) begin @(negedge clk); if (done) dn++; end
        check(dn == 0, "R9 no extra done", dn, 0);
    endtask

    initial begin
        for (int d = 0; d < 2; d++) cfg(d, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (4) @(negedge clk);
        check(!done && !bus_rd && !bus_wr, "R9 reset quiet", {done, bus_rd, bus_wr}, 0);
        check(dev_type == '0 && dev_capacity == '0 && dev_err == '0, "R9 reset results",
              dev_type, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // A: plain CHS disk, packet slave
        cfg(0, 8'h50, 0, 0, 16'd1000, 16'd16, 16'd63, 8'h00, 0, 0, 0, 2, 1);
        cfg(1, 8'h00, 8'h14, 8'hEB, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        run_probe(3);
        // B: big geometry with LBA, busy slave with ready bits
        cfg(0, 8'h50, 0, 0, 16'd16383, 16'd16, 16'd63, 8'h02, 16'h0007, 16'h007E, 32'h0123_4567, 0, 1);
        cfg(1, 8'hD0, 8'h14, 8'hEB, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        run_probe(0);
        // C: big geometry without LBA, half signature
        cfg(0, 8'h50, 0, 0, 16'd16383, 16'd16, 16'd63, 8'h02, 16'h0001, 16'h0000, 32'h0000_0011, 1, 1);
        cfg(1, 8'h00, 8'h14, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        run_probe(7);
        // D: DSC-only disk never giving DRQ; slave with one LBA condition missing
        cfg(0, 8'h10, 0, 0, 16'd900, 16'd2, 16'd9, 8'h02, 16'h0001, 16'h0001, 32'h1, 3, 0);
        cfg(1, 8'h40, 0, 0, 16'd200, 16'd4, 16'd17, 8'h02, 16'h0006, 16'h0001, 32'h1, 5, 1);
        run_probe(1);
        // E: poll timeout on master, LBA-capable ordinary slave
        cfg(0, 8'h50, 0, 0, 16'd10, 16'd2, 16'd3, 0, 0, 0, 0, 40000, 1);
        cfg(1, 8'h50, 0, 0, 16'd500, 16'd8, 16'd32, 8'h02, 16'h0001, 16'h0010, 32'hFFFF_FFFF, 0, 1);
        run_probe(2);
        check(sb_q.size() == 0, "R9 all results seen", sb_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R9 watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule